// File: doc/BRIEF.md
# Three-Dimensional Byte Block Copier

This block copies a rectangular, possibly strided, set of bytes from one memory region to another without processor help. Software sets it going by writing the byte address of a 48-byte descriptor into one fixed parameter slot. The block then reads the descriptor through a single request/acknowledge memory port. After that it moves bytes one at a time through three nested loops: an inner run of contiguous bytes, a middle level stepped by a B pitch and an outer level stepped by a C pitch. Source and destination each have their own pair of pitches.

Only the source counts bound the loops. The destination counts are fetched and thrown away. The only option word accepted is 0x80000000. Any other value ends the job at once with an error flag. A `busy` level covers the whole job, and a one-cycle `done` pulse marks its end whether the job copied bytes, copied nothing or failed.

Top module: `blk3d_xfer`

## Requirements
- R1: A write with `prm_wr` high and `prm_idx` equal to 0x3F while `busy` is low starts a job, and `prm_wdata` is taken as the descriptor byte address. `busy` is high from the next cycle until the cycle after `done`.
- R2: The descriptor is read as twelve 32-bit words at descriptor address plus 4·k. Each word is little-endian: byte at the lowest address sits in bits 7:0. Options are at +4, source base at +8, destination base at +12, source C count at +24, source B pitch at +32, destination B pitch at +36, source C pitch at +40 and destination C pitch at +44. The word at +16 carries the source B count in bits 15:0 and the source A count in bits 31:16. The words at +0, +20 and +28 are read and discarded.
- R3: For c from 0 to the C count inclusive, b from 0 to the B count inclusive and a from 0 to A count minus 1, one byte moves from source base + c·(source C pitch) + b·(source B pitch) + a to destination base + c·(destination C pitch) + b·(destination B pitch) + a. Nothing else is written.
- R4: The destination A, B and C counts have no effect on the bytes copied.
- R5: An option word other than 0x80000000 raises `err` together with `done`, and no byte is read or written.
- R6: A source A count of zero copies no byte and still gives `done`.
- R7: `done` lasts exactly one cycle, with `busy` high in that cycle. `err` holds its value until the next job starts, and a new job clears it.
- R8: A start write while `busy` is high is ignored. A write to any slot other than 0x3F starts nothing.
- R9: At most one access is outstanding. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`. Descriptor reads have `mem_word` high. Byte reads take data from `mem_rdata[7:0]`, and byte writes drive `mem_wdata` with `mem_word` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prm_wr | input | 1 | Parameter slot write strobe |
| prm_idx | input | 11 | Parameter slot word index |
| prm_wdata | input | 32 | Parameter write data (descriptor address on start) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 1 | 1: 32-bit descriptor read, 0: byte access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Read data, little-endian |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Last job was rejected for its option word |

## Verification
A wrong descriptor field or a slipped index shows up as a destination byte that is wrong, missing or written outside the expected footprint. A wrong loop bound changes how many byte writes are acknowledged. Both are visible only once `done` arrives, so the destination window and the write count are compared right after each job. Stepping the counts through small values, both with and without inclusive outer levels, exposes off-by-one errors within a single job. Control faults such as a missed abort, a double start or a stretched pulse show at `err`, `busy` and `done` within a cycle or two of the event.

// File: rtl/blk3d_pkg.sv
// Shared constants and types of the block copier.
// Assumes the fixed 48-byte descriptor format: twelve 32-bit words.
package blk3d_pkg;
    localparam int unsigned DESC_WORDS = 12;
    localparam logic [31:0] OPT_PLAIN  = 32'h8000_0000;

    // descriptor word slots (byte offset / 4); the order is the fetch order
    localparam int unsigned W_OPT   = 1;
    localparam int unsigned W_SBASE = 2;
    localparam int unsigned W_DBASE = 3;
    localparam int unsigned W_SAB   = 4;
    localparam int unsigned W_SC    = 6;
    localparam int unsigned W_SBP   = 8;
    localparam int unsigned W_DBP   = 9;
    localparam int unsigned W_SCP   = 10;
    localparam int unsigned W_DCP   = 11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC, ST_SETUP, ST_RD, ST_WR, ST_FIN
    } xfer_st_t;

    typedef struct packed {
        logic [31:0] src_base;
        logic [31:0] dst_base;
        logic [15:0] a_cnt;
        logic [15:0] b_cnt;
        logic [31:0] c_cnt;
        logic [31:0] src_bp;
        logic [31:0] dst_bp;
        logic [31:0] src_cp;
        logic [31:0] dst_cp;
    } desc_t;
endpackage

// File: rtl/blk3d_desc_regs.sv
// Captures descriptor words into the fields the copy needs.
// Assumes one word arrives per load strobe with its slot index;
// link word and destination counts are dropped as they arrive.
module blk3d_desc_regs
    import blk3d_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [3:0]  widx,
    input  logic [31:0] wdata,
    output desc_t       desc
);
    // store the arriving word in the field its slot names
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (ld) begin
            case (int'(widx))
                W_SBASE: desc.src_base <= wdata;
                W_DBASE: desc.dst_base <= wdata;
                W_SAB: begin
                    desc.b_cnt <= wdata[15:0];
                    desc.a_cnt <= wdata[31:16];
                end
                W_SC:    desc.c_cnt  <= wdata;
                W_SBP:   desc.src_bp <= wdata;
                W_DBP:   desc.dst_bp <= wdata;
                W_SCP:   desc.src_cp <= wdata;
                W_DCP:   desc.dst_cp <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/blk3d_addr_walk.sv
// Running address of one channel: a plane pointer stepped by the C pitch
// and a row pointer stepped by the B pitch, so no multiplier is needed.
// Assumes step_c and step_b are never requested together.
module blk3d_addr_walk #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step_b,
    input  logic          step_c,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] b_pitch,
    input  logic [AW-1:0] c_pitch,
    output logic [AW-1:0] row
);
    logic [AW-1:0] plane;

    // advance plane and row pointers as the outer indices move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane <= '0;
            row   <= '0;
        end else if (init) begin
            plane <= base;
            row   <= base;
        end else if (step_c) begin
            plane <= plane + c_pitch;
            row   <= plane + c_pitch;
        end else if (step_b) begin
            row   <= row + b_pitch;
        end
    end
endmodule

// File: rtl/blk3d_iter.sv
// Three nested index counters: inner exclusive of its count, the two
// outer levels inclusive. Assumes a_cnt is nonzero whenever adv is used.
module blk3d_iter #(
    parameter int unsigned AW_CNT = 16,
    parameter int unsigned CW_CNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              adv,
    input  logic              run,
    input  logic [AW_CNT-1:0] a_cnt,
    input  logic [AW_CNT-1:0] b_cnt,
    input  logic [CW_CNT-1:0] c_cnt,
    output logic [AW_CNT-1:0] a_idx,
    output logic              step_b,
    output logic              step_c,
    output logic              last
);
    logic [AW_CNT-1:0] b_idx;
    logic [CW_CNT-1:0] c_idx;
    logic a_wrap, b_wrap, c_wrap;

    // end-of-level detection for each index
    always_comb begin
        a_wrap = (a_idx == a_cnt - AW_CNT'(1));
        b_wrap = (b_idx == b_cnt);
        c_wrap = (c_idx == c_cnt);
        last   = a_wrap && b_wrap && c_wrap;
        step_b = adv && a_wrap && !b_wrap;
        step_c = adv && a_wrap && b_wrap && !c_wrap;
    end

    // ripple the indices forward by one byte per advance
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            a_idx <= '0;
            b_idx <= '0;
            c_idx <= '0;
        end else if (adv) begin
            if (!a_wrap) begin
                a_idx <= a_idx + AW_CNT'(1);
            end else begin
                a_idx <= '0;
                if (!b_wrap) begin
                    b_idx <= b_idx + AW_CNT'(1);
                end else begin
                    b_idx <= '0;
                    if (!c_wrap) c_idx <= c_idx + CW_CNT'(1);
                end
            end
        end
    end

    // R3
    a_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (a_idx < a_cnt));

    // R3
    b_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (b_idx <= b_cnt));
endmodule

// File: rtl/blk3d_ctrl.sv
// Job sequencer: waits for a start, fetches descriptor words, screens the
// option word, then alternates byte read and byte write until the last
// index. Assumes a memory that acknowledges each held request once.
module blk3d_ctrl
    import blk3d_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig,
    input  logic [31:0] trig_addr,
    input  logic        a_zero,
    input  logic        last,
    input  logic [31:0] src_addr,
    input  logic [31:0] dst_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_word,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        ld_desc,
    output logic [3:0]  widx,
    output logic        init,
    output logic        adv,
    output logic        run,
    output logic        busy,
    output logic        done,
    output logic        err
);
    localparam logic [3:0] LAST_W = 4'(DESC_WORDS - 1);
    localparam logic [3:0] OPT_W  = 4'(W_OPT);

    xfer_st_t    st;
    logic [31:0] desc_ptr;
    logic [7:0]  byte_q;

    // sequence state, descriptor slot, held byte and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            desc_ptr <= '0;
            widx     <= '0;
            byte_q   <= '0;
            err      <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (trig) begin
                    desc_ptr <= trig_addr;
                    widx     <= '0;
                    err      <= 1'b0;
                    st       <= ST_DESC;
                end
                ST_DESC: if (mem_ack) begin
                    if (widx == OPT_W && mem_rdata != OPT_PLAIN) begin
                        err <= 1'b1;
                        st  <= ST_FIN;
                    end else if (widx == LAST_W) begin
                        st <= ST_SETUP;
                    end else begin
                        widx <= widx + 4'd1;
                    end
                end
                ST_SETUP: st <= a_zero ? ST_FIN : ST_RD;
                ST_RD: if (mem_ack) begin
                    byte_q <= mem_rdata[7:0];
                    st     <= ST_WR;
                end
                ST_WR: if (mem_ack) st <= last ? ST_FIN : ST_RD;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory port and strobes toward the datapath
    always_comb begin
        mem_req   = (st == ST_DESC) || (st == ST_RD) || (st == ST_WR);
        mem_we    = (st == ST_WR);
        mem_word  = (st == ST_DESC);
        mem_wdata = byte_q;
        case (st)
            ST_DESC: mem_addr = desc_ptr + {26'd0, widx, 2'b00};
            ST_RD:   mem_addr = src_addr;
            default: mem_addr = dst_addr;
        endcase
        ld_desc = (st == ST_DESC) && mem_ack;
        init    = (st == ST_SETUP);
        adv     = (st == ST_WR) && mem_ack;
        run     = (st == ST_RD) || (st == ST_WR);
        busy    = (st != ST_IDLE);
        done    = (st == ST_FIN);
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    write_is_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_word);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/blk3d_xfer.sv
// Top of the block copier: decodes the start slot, holds the descriptor,
// walks the three indices and forms source and destination addresses
// from two identical pointer walkers. Assumes 32-bit byte addresses.
module blk3d_xfer
    import blk3d_pkg::*;
#(
    parameter int unsigned     PRM_IDX_W = 11,
    parameter logic [10:0]     TRIG_SLOT = 11'h03F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prm_wr,
    input  logic [PRM_IDX_W-1:0] prm_idx,
    input  logic [31:0]          prm_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_word,
    output logic [31:0]          mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int unsigned NCH = 2;   // channel 0 source, 1 destination

    desc_t       desc;
    logic        trig, ld_desc, init, adv, run, last, step_b, step_c;
    logic [3:0]  widx;
    logic [15:0] a_idx;
    logic [31:0] src_addr, dst_addr;
    logic [31:0] ch_base [NCH];
    logic [31:0] ch_bp   [NCH];
    logic [31:0] ch_cp   [NCH];
    logic [31:0] ch_row  [NCH];

    // start request decode
    assign trig = prm_wr && (prm_idx == PRM_IDX_W'(TRIG_SLOT));

    blk3d_desc_regs u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_desc),
        .widx  (widx),
        .wdata (mem_rdata),
        .desc  (desc)
    );

    blk3d_iter #(.AW_CNT(16), .CW_CNT(32)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (init),
        .adv    (adv),
        .run    (run),
        .a_cnt  (desc.a_cnt),
        .b_cnt  (desc.b_cnt),
        .c_cnt  (desc.c_cnt),
        .a_idx  (a_idx),
        .step_b (step_b),
        .step_c (step_c),
        .last   (last)
    );

    // per-channel base and pitches
    assign ch_base[0] = desc.src_base;
    assign ch_bp[0]   = desc.src_bp;
    assign ch_cp[0]   = desc.src_cp;
    assign ch_base[1] = desc.dst_base;
    assign ch_bp[1]   = desc.dst_bp;
    assign ch_cp[1]   = desc.dst_cp;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_walk
        blk3d_addr_walk #(.AW(32)) u_walk (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (init),
            .step_b  (step_b),
            .step_c  (step_c),
            .base    (ch_base[ch]),
            .b_pitch (ch_bp[ch]),
            .c_pitch (ch_cp[ch]),
            .row     (ch_row[ch])
        );
    end

    // byte addresses: row pointer plus inner index
    assign src_addr = ch_row[0] + {16'd0, a_idx};
    assign dst_addr = ch_row[1] + {16'd0, a_idx};

    blk3d_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_addr (prm_wdata),
        .a_zero    (desc.a_cnt == 16'd0),
        .last      (last),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ld_desc   (ld_desc),
        .widx      (widx),
        .init      (init),
        .adv       (adv),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );
endmodule

// File: tb/test_blk3d_xfer.sv
module test_blk3d_xfer;
    localparam int CLK_PERIOD = 10;
    localparam int MSZ        = 4096;
    localparam int DWIN       = 12'h800;
    localparam int SBASE      = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prm_wr = 1'b0;
    logic [10:0] prm_idx = '0;
    logic [31:0] prm_wdata = '0;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, err;

    logic [7:0]  mem [MSZ];
    logic [7:0]  expw [256];
    logic [11:0] ma;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk3d_xfer i_blk3d_xfer (
        .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_idx(prm_idx),
        .prm_wdata(prm_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .err(err)
    );

    // memory model: one acknowledge per request, serviced away from the edge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            ma = mem_addr[11:0];
            if (mem_we) begin
                mem[ma] = mem_wdata;
                wr_cnt++;
            end else if (mem_word) begin
                mem_rdata = {mem[ma+12'd3], mem[ma+12'd2], mem[ma+12'd1], mem[ma]};
            end else begin
                mem_rdata = {24'd0, mem[ma]};
            end
            mem_ack = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) % MSZ] = v[8*k +: 8];
    endtask

    task automatic mk_desc(input int d, input logic [31:0] opt,
                           input int sb, input int db, input int a, input int b,
                           input int c, input int sbp, input int dbp,
                           input int scp, input int dcp);
        put32(d + 0,  32'hDEAD_0001);
        put32(d + 4,  opt);
        put32(d + 8,  sb);
        put32(d + 12, db);
        put32(d + 16, {16'(a), 16'(b)});
        put32(d + 20, {16'd1, 16'd0});      // destination counts: junk
        put32(d + 24, c);
        put32(d + 28, 32'd0);
        put32(d + 32, sbp);
        put32(d + 36, dbp);
        put32(d + 40, scp);
        put32(d + 44, dcp);
    endtask

    task automatic prm_write(input logic [10:0] slot, input logic [31:0] v);
        @(negedge clk);
        prm_wr = 1'b1; prm_idx = slot; prm_wdata = v;
        @(negedge clk);
        prm_wr = 1'b0;
    endtask

    // wait for done; report error flag and pulse shape
    task automatic wait_done(output bit e);
        int n = 0;
        e = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, "R7", "done seen", done, 1);
        chk(busy === 1'b1, "R7", "busy during done", busy, 1);
        e = err;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R7", "done one cycle", {done, busy}, 0);
    endtask

    task automatic clear_win();
        for (int i = 0; i < 256; i++) begin
            mem[DWIN + i] = 8'h00;
            expw[i] = 8'h00;
        end
    endtask

    function automatic int win_mismatch();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[DWIN + i] !== expw[i]) m++;
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit e;
        int w0;
        for (int i = 0; i < MSZ; i++) mem[i] = 8'((i * 13 + 5) ^ (i >> 8));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(busy === 1'b0, "R1", "reset busy", busy, 0);
        chk(done === 1'b0, "R7", "reset done", done, 0);
        chk(err === 1'b0, "R5", "reset err", err, 0);
        chk(mem_req === 1'b0, "R9", "reset req", mem_req, 0);

        // R8: write to a neighbouring slot starts nothing
        mk_desc(12'h040, 32'h8000_0000, SBASE, DWIN, 2, 0, 0, 4, 4, 8, 8);
        w0 = wr_cnt;
        prm_write(11'h03E, 32'h40);
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && wr_cnt == w0, "R8", "other slot idle", wr_cnt - w0, 0);

        // R5: rejected option word
        clear_win();
        mk_desc(12'h040, 32'h8000_0001, SBASE, DWIN, 3, 1, 1, 4, 4, 16, 16);
        w0 = wr_cnt;
        prm_write(11'h03F, 32'h40);
        chk(busy === 1'b1, "R1", "busy after start", busy, 1);
        wait_done(e);
        chk(e == 1'b1, "R5", "err on bad option", e, 1);
        chk(wr_cnt == w0, "R5", "no writes on abort", wr_cnt - w0, 0);
        chk(win_mismatch() == 0, "R5", "window untouched", win_mismatch(), 0);
        chk(err === 1'b1, "R7", "err held", err, 1);

        // R6: zero inner count, also clears err (R7)
        mk_desc(12'h040, 32'h8000_0000, SBASE, DWIN, 0, 2, 1, 4, 4, 16, 16);
        w0 = wr_cnt;
        prm_write(11'h03F, 32'h40);
        wait_done(e);
        chk(e == 1'b0, "R7", "err cleared by new job", e, 0);
        chk(wr_cnt == w0, "R6", "zero A copies nothing", wr_cnt - w0, 0);
        chk(win_mismatch() == 0, "R6", "window untouched", win_mismatch(), 0);

        // R3 R4 R2: sweep of small shapes
        for (int a = 1; a <= 3; a++)
            for (int b = 0; b <= 2; b++)
                for (int c = 0; c <= 2; c++) begin
                    int sbp = a + 3;
                    int scp = 40;
                    int dbp = a + 1;
                    int dcp = (b + 1) * (a + 1) + 5;
                    clear_win();
                    for (int ic = 0; ic <= c; ic++)
                        for (int ib = 0; ib <= b; ib++)
                            for (int ia = 0; ia < a; ia++)
                                expw[ic*dcp + ib*dbp + ia] =
                                    mem[SBASE + ic*scp + ib*sbp + ia];
                    mk_desc(12'h040, 32'h8000_0000, SBASE, DWIN, a, b, c,
                            sbp, dbp, scp, dcp);
                    w0 = wr_cnt;
                    prm_write(11'h03F, 32'h40);
                    wait_done(e);
                    chk(e == 1'b0, "R2", "no err on valid option", e, 0);
                    chk(wr_cnt - w0 == (c+1)*(b+1)*a, "R4",
                        "write count from source counts", wr_cnt - w0, (c+1)*(b+1)*a);
                    chk(win_mismatch() == 0, "R3", "destination bytes",
                        win_mismatch(), 0);
                end

        // R8: second start while busy is ignored
        clear_win();
        mk_desc(12'h040, 32'h8000_0000, SBASE, DWIN, 2, 1, 0, 5, 3, 40, 40);
        mk_desc(12'h080, 32'h1234_5678, SBASE, DWIN, 1, 0, 0, 1, 1, 1, 1);
        for (int ib = 0; ib <= 1; ib++)
            for (int ia = 0; ia < 2; ia++)
                expw[ib*3 + ia] = mem[SBASE + ib*5 + ia];
        w0 = wr_cnt;
        prm_write(11'h03F, 32'h40);
        prm_write(11'h03F, 32'h80);
        wait_done(e);
        chk(e == 1'b0, "R8", "busy start ignored, no err", e, 0);
        chk(wr_cnt - w0 == 4, "R8", "first job only", wr_cnt - w0, 4);
        chk(win_mismatch() == 0, "R8", "first job bytes", win_mismatch(), 0);
        repeat (30) @(negedge clk);
        chk(busy === 1'b0, "R8", "no queued job", busy, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule